// File: doc/BRIEF.md
# Contact Card Power Sequencer

This block brings a contact smart card up and down in a fixed, safe order. When the host pulls its active-low session request low and a card is seated, the block turns on the card supply. It then enables the I/O line, then starts the card clock, and finally lets the host's reset command through to the card. Each step is held for `ACT_GAP` reference-clock cycles before the next one. When the host drops its request, the card is removed, or any supervisor raises a fault, the block undoes these steps in reverse, one every `DEACT_GAP` cycles. Card reset goes first, then the clock, then I/O, and the supply is switched off last.

The host watches a single active-low interrupt line. While no session is requested, the line only reports whether a card is seated. While a session is requested, the line goes low when a fault has ended the session. It stays low until the host withdraws the request. A fault also blocks any new start until the request has been withdrawn and asserted again. All inputs are assumed to be synchronous to `clk`.

Top module: `cardif_sequencer`

## Requirements
- R1: A card counts as seated when `det_hi` is 1 or `det_lo_n` is 0. While `act_req_n` is 1, `irq_n` equals this seated flag, whatever the fault inputs are.
- R2: `pwr_en` rises only at the clock edge after a cycle in which `act_req_n` was 0, a card was seated, no fault input was 1 and no fault was latched. At that edge `io_en` and `clk_en` are still 0.
- R3: `io_en` rises `ACT_GAP` cycles after `pwr_en`, and `clk_en` rises `ACT_GAP` cycles after `io_en`. Reset pass-through opens `ACT_GAP` cycles after `clk_en`. The block never has `clk_en` on without `io_en`, nor `io_en` on without `pwr_en`.
- R4: `card_rst` equals `host_rst` only while the card is fully active. At all other times it is 0.
- R5: Any of the six fault inputs at 1, or removal of the card, forces `card_rst` to 0 at the next edge if it occurs during power-up or while active.
- R6: After the edge that starts a deactivation, `clk_en` falls `DEACT_GAP` cycles later, `io_en` falls `2*DEACT_GAP` cycles later, and `pwr_en` falls `3*DEACT_GAP` cycles later.
- R7: While `act_req_n` is 0, `irq_n` goes low the cycle after a fault or removal is seen. It stays low until `act_req_n` returns to 1, even if the fault clears.
- R8: After a fault, no new power-up starts while `act_req_n` stays 0. Returning it to 1 and then 0 again starts a new power-up.
- R9: Raising `act_req_n` during a session runs the same ordered deactivation as R6. `irq_n` then reports presence.
- R10: A `flt_vdd` fault while idle keeps the block idle with all card outputs at 0, even with the request asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst_n | input | 1 | synchronous active-low reset |
| act_req_n | input | 1 | host session request, active low |
| host_rst | input | 1 | host reset command for the card |
| det_hi | input | 1 | card-seated switch, active high |
| det_lo_n | input | 1 | card-seated switch, active low |
| flt_vdd | input | 1 | digital supply low |
| flt_vpc | input | 1 | regulator input supply low |
| flt_vcc | input | 1 | card supply low |
| flt_ovc | input | 1 | card over-current |
| flt_hot | input | 1 | over-temperature |
| flt_vpc_lt_vcc | input | 1 | regulator input has fallen below card supply |
| pwr_en | output | 1 | card supply enable |
| card_rst | output | 1 | reset level driven to the card |
| clk_en | output | 1 | card clock enable (clock held low when 0) |
| io_en | output | 1 | card I/O enable (I/O held low when 0) |
| irq_n | output | 1 | host interrupt, active low |

## Verification
The assertions check several rules on every cycle:
- the nesting of supply, I/O and clock enables;
- that card reset only passes through while the clock runs;
- that a fault kills card reset at the next edge;
- that the latched interrupt holds while the request stays low;
- that a power-up only begins from a request with a seated card;
- that supply-off only happens after clock and I/O are off.

The exact step spacing of `ACT_GAP` and `DEACT_GAP` needs the bench's scenarios, which count cycles from known edges. So do the lockout until the request is toggled, the behaviour of each fault source and each presence polarity, and the blocked start under a digital-supply fault.

// File: rtl/cardif_pkg.sv
// Shared types for the contact card sequencer.
// Assumes: fault flags are collected into one vector in the index order below.
package cardif_pkg;
    localparam int NUM_FAULTS = 6;
    localparam int FI_VDD = 0;
    localparam int FI_VPC = 1;
    localparam int FI_VCC = 2;
    localparam int FI_OVC = 3;
    localparam int FI_HOT = 4;
    localparam int FI_VPC_LT_VCC = 5;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_UP_PWR = 3'd1,
        SQ_UP_IO  = 3'd2,
        SQ_UP_CLK = 3'd3,
        SQ_LIVE   = 3'd4,
        SQ_DN_RST = 3'd5,
        SQ_DN_CLK = 3'd6,
        SQ_DN_IO  = 3'd7
    } seq_state_t;
endpackage

// File: rtl/cardif_fault_merge.sv
// Combines the two presence switches and the supervisor flags.
// Assumes: all inputs are already synchronous to the sequencer clock.
module cardif_fault_merge #(
    parameter int NF = 6
) (
    input  logic          det_hi,
    input  logic          det_lo_n,
    input  logic [NF-1:0] flt,
    output logic          present,
    output logic          fault_any
);
    // Seated if either switch polarity reports a card; removal counts as a fault.
    always_comb begin
        present   = det_hi | ~det_lo_n;
        fault_any = (|flt) | ~present;
    end
endmodule

// File: rtl/cardif_step_timer.sv
// Down-counter that spaces the sequencer steps.
// Assumes: load_val is the step length minus one; done is high once it reaches zero.
module cardif_step_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Reload on a state change, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/cardif_sequencer.sv
// Contact card power sequencer.
// Power-up order: supply, I/O, clock, then reset pass-through, ACT_GAP cycles apart.
// Power-down runs in reverse, DEACT_GAP cycles apart, on release, removal or a fault.
// Assumes: synchronous inputs, ACT_GAP >= 1, DEACT_GAP >= 1.
module cardif_sequencer #(
    parameter int ACT_GAP   = 4,
    parameter int DEACT_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_req_n,
    input  logic host_rst,
    input  logic det_hi,
    input  logic det_lo_n,
    input  logic flt_vdd,
    input  logic flt_vpc,
    input  logic flt_vcc,
    input  logic flt_ovc,
    input  logic flt_hot,
    input  logic flt_vpc_lt_vcc,
    output logic pwr_en,
    output logic card_rst,
    output logic clk_en,
    output logic io_en,
    output logic irq_n
);
    import cardif_pkg::*;

    localparam int MAXG = (ACT_GAP > DEACT_GAP) ? ACT_GAP : DEACT_GAP;
    localparam int CW   = $clog2(MAXG + 1);
    localparam logic [CW-1:0] ACT_LD   = CW'(ACT_GAP - 1);
    localparam logic [CW-1:0] DEACT_LD = CW'(DEACT_GAP - 1);

    logic [NUM_FAULTS-1:0] flt;
    logic present, fault_any, req, abort, done;
    logic flt_lat_q, pwr_q, io_q, clk_q, live_q;
    logic load;
    logic [CW-1:0] load_val;
    seq_state_t st_q, nxt;

    // Gather the supervisor flags in package index order.
    always_comb begin
        flt                = '0;
        flt[FI_VDD]        = flt_vdd;
        flt[FI_VPC]        = flt_vpc;
        flt[FI_VCC]        = flt_vcc;
        flt[FI_OVC]        = flt_ovc;
        flt[FI_HOT]        = flt_hot;
        flt[FI_VPC_LT_VCC] = flt_vpc_lt_vcc;
    end

    cardif_fault_merge #(.NF(NUM_FAULTS)) u_merge (
        .det_hi   (det_hi),
        .det_lo_n (det_lo_n),
        .flt      (flt),
        .present  (present),
        .fault_any(fault_any)
    );

    cardif_step_timer #(.W(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .done    (done)
    );

    assign req   = ~act_req_n;
    assign abort = ~req | fault_any;

    // Next-state decision; power-up steps can abort, power-down steps cannot.
    always_comb begin
        nxt = st_q;
        unique case (st_q)
            SQ_IDLE:   if (req && !fault_any && !flt_lat_q) nxt = SQ_UP_PWR;
            SQ_UP_PWR: if (abort) nxt = SQ_DN_RST; else if (done) nxt = SQ_UP_IO;
            SQ_UP_IO:  if (abort) nxt = SQ_DN_RST; else if (done) nxt = SQ_UP_CLK;
            SQ_UP_CLK: if (abort) nxt = SQ_DN_RST; else if (done) nxt = SQ_LIVE;
            SQ_LIVE:   if (abort) nxt = SQ_DN_RST;
            SQ_DN_RST: if (done) nxt = SQ_DN_CLK;
            SQ_DN_CLK: if (done) nxt = SQ_DN_IO;
            SQ_DN_IO:  if (done) nxt = SQ_IDLE;
            default:   nxt = SQ_IDLE;
        endcase
    end

    // Restart the step timer on every transition with the gap of the new phase.
    always_comb begin
        load     = (nxt != st_q);
        load_val = (nxt == SQ_DN_RST || nxt == SQ_DN_CLK || nxt == SQ_DN_IO) ? DEACT_LD : ACT_LD;
    end

    // State, output enables and the fault latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SQ_IDLE;
            pwr_q     <= 1'b0;
            io_q      <= 1'b0;
            clk_q     <= 1'b0;
            live_q    <= 1'b0;
            flt_lat_q <= 1'b0;
        end else begin
            st_q      <= nxt;
            flt_lat_q <= req & (flt_lat_q | fault_any);
            live_q    <= (nxt == SQ_LIVE);
            if (nxt == SQ_UP_PWR)     pwr_q <= 1'b1;
            else if (nxt == SQ_IDLE)  pwr_q <= 1'b0;
            if (nxt == SQ_UP_IO)      io_q  <= 1'b1;
            else if (nxt == SQ_DN_IO) io_q  <= 1'b0;
            if (nxt == SQ_UP_CLK)     clk_q <= 1'b1;
            else if (nxt == SQ_DN_CLK) clk_q <= 1'b0;
        end
    end

    // Drive the card and host outputs.
    always_comb begin
        pwr_en   = pwr_q;
        io_en    = io_q;
        clk_en   = clk_q;
        card_rst = live_q & host_rst;
        irq_n    = req ? ~flt_lat_q : present;
    end
endmodule

// File: rtl/cardif_sequencer_chk.sv
// Property checker for the contact card sequencer, bound to its ports.
// Assumes: only top-level ports are observed.
module cardif_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic act_req_n,
    input logic host_rst,
    input logic det_hi,
    input logic det_lo_n,
    input logic flt_vdd,
    input logic flt_vpc,
    input logic flt_vcc,
    input logic flt_ovc,
    input logic flt_hot,
    input logic flt_vpc_lt_vcc,
    input logic pwr_en,
    input logic card_rst,
    input logic clk_en,
    input logic io_en,
    input logic irq_n
);
    logic seated, any_bad;
    assign seated  = det_hi | ~det_lo_n;
    assign any_bad = flt_vdd | flt_vpc | flt_vcc | flt_ovc | flt_hot | flt_vpc_lt_vcc | ~seated;

    assert_idle_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        act_req_n |-> (irq_n == seated));

    assert_start_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> ($past(!act_req_n && seated) && !io_en && !clk_en));

    assert_nest_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> io_en);

    assert_nest_io_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> pwr_en);

    assert_rst_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (clk_en && host_rst));

    assert_fault_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_bad && pwr_en) |=> !card_rst);

    assert_off_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> (!io_en && !clk_en && !card_rst));

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_req_n && !irq_n) |=> (act_req_n || !irq_n));

    assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_req_n && !irq_n && !pwr_en) |=> !pwr_en);
endmodule

bind cardif_sequencer cardif_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .act_req_n(act_req_n), .host_rst(host_rst),
    .det_hi(det_hi), .det_lo_n(det_lo_n), .flt_vdd(flt_vdd), .flt_vpc(flt_vpc),
    .flt_vcc(flt_vcc), .flt_ovc(flt_ovc), .flt_hot(flt_hot),
    .flt_vpc_lt_vcc(flt_vpc_lt_vcc), .pwr_en(pwr_en), .card_rst(card_rst),
    .clk_en(clk_en), .io_en(io_en), .irq_n(irq_n)
);

// File: tb/cardif_sequencer_test.sv
`timescale 1ns/100ps
module cardif_sequencer_test;
    localparam int AG = 4;
    localparam int DG = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_req_n = 1'b1, host_rst = 1'b0, det_hi = 1'b0, det_lo_n = 1'b1;
    logic flt_vdd = 1'b0, flt_vpc = 1'b0, flt_vcc = 1'b0, flt_ovc = 1'b0, flt_hot = 1'b0, flt_pvc = 1'b0;
    logic pwr_en, card_rst, clk_en, io_en, irq_n;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cardif_sequencer #(.ACT_GAP(AG), .DEACT_GAP(DG)) uut (
        .clk(clk), .rst_n(rst_n), .act_req_n(act_req_n), .host_rst(host_rst),
        .det_hi(det_hi), .det_lo_n(det_lo_n), .flt_vdd(flt_vdd), .flt_vpc(flt_vpc),
        .flt_vcc(flt_vcc), .flt_ovc(flt_ovc), .flt_hot(flt_hot), .flt_vpc_lt_vcc(flt_pvc),
        .pwr_en(pwr_en), .card_rst(card_rst), .clk_en(clk_en), .io_en(io_en), .irq_n(irq_n)
    );

    // Vector bits: [8] det_hi, [7] det_lo_n, [6:1] vdd,vpc,vcc,ovc,hot,vpc<vcc, [0] expected irq_n.
    localparam logic [8:0] VEC [6] = '{
        9'b0_1_000000_0, 9'b1_1_000000_1, 9'b0_0_000000_1,
        9'b1_0_000000_1, 9'b0_1_111111_0, 9'b1_1_100001_1
    };

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        chk("reset pwr_en", pwr_en, 1'b0);
        chk("reset io_en", io_en, 1'b0);
        chk("reset clk_en", clk_en, 1'b0);
        chk("reset card_rst", card_rst, 1'b0);

        // R1 table: presence reporting with no request, faults ignored.
        for (int i = 0; i < 6; i++) begin
            det_hi = VEC[i][8]; det_lo_n = VEC[i][7];
            {flt_vdd, flt_vpc, flt_vcc, flt_ovc, flt_hot, flt_pvc} = VEC[i][6:1];
            tick(2);
            chk("R1 irq_n presence", irq_n, VEC[i][0]);
            chk("R1 idle pwr_en", pwr_en, 1'b0);
        end
        {flt_vdd, flt_vpc, flt_vcc, flt_ovc, flt_hot, flt_pvc} = '0;
        det_hi = 1'b1; det_lo_n = 1'b1; host_rst = 1'b1;
        tick(1);

        // R2/R3/R4: full power-up with step spacing.
        act_req_n = 1'b0;
        tick(1);
        chk("R2 pwr_en first", pwr_en, 1'b1);
        chk("R2 io_en not yet", io_en, 1'b0);
        tick(AG - 1);
        chk("R3 io_en before gap", io_en, 1'b0);
        tick(1);
        chk("R3 io_en after gap", io_en, 1'b1);
        tick(AG - 1);
        chk("R3 clk_en before gap", clk_en, 1'b0);
        tick(1);
        chk("R3 clk_en after gap", clk_en, 1'b1);
        chk("R4 card_rst gated", card_rst, 1'b0);
        tick(AG);
        chk("R4 card_rst passes 1", card_rst, 1'b1);
        host_rst = 1'b0; #1;
        chk("R4 card_rst passes 0", card_rst, 1'b0);
        host_rst = 1'b1; #1;
        chk("R7 irq_n high in session", irq_n, 1'b1);

        // R5/R6/R7: over-current during session.
        flt_ovc = 1'b1;
        tick(1);
        chk("R5 card_rst killed", card_rst, 1'b0);
        chk("R7 irq_n low", irq_n, 1'b0);
        chk("R6 clk_en still on", clk_en, 1'b1);
        tick(DG);
        chk("R6 clk_en off", clk_en, 1'b0);
        chk("R6 io_en still on", io_en, 1'b1);
        tick(DG);
        chk("R6 io_en off", io_en, 1'b0);
        chk("R6 pwr_en still on", pwr_en, 1'b1);
        tick(DG);
        chk("R6 pwr_en off", pwr_en, 1'b0);
        flt_ovc = 1'b0;
        tick(5);
        chk("R7 irq_n latched", irq_n, 1'b0);
        chk("R8 no restart", pwr_en, 1'b0);
        act_req_n = 1'b1;
        tick(1);
        chk("R7 irq_n released", irq_n, 1'b1);
        act_req_n = 1'b0;
        tick(1);
        chk("R8 restart after toggle", pwr_en, 1'b1);

        // R9: host release during session.
        tick(3 * AG);
        chk("R9 active before release", card_rst, 1'b1);
        act_req_n = 1'b1;
        tick(1);
        chk("R9 card_rst low", card_rst, 1'b0);
        chk("R9 irq_n presence", irq_n, 1'b1);
        tick(DG);
        chk("R9 clk_en off", clk_en, 1'b0);
        tick(2 * DG);
        chk("R9 pwr_en off", pwr_en, 1'b0);

        // R5 via VPC below VCC.
        act_req_n = 1'b0;
        tick(1 + 3 * AG);
        chk("R5 active again", card_rst, 1'b1);
        flt_pvc = 1'b1;
        tick(1);
        chk("R5 vpc<vcc kills card_rst", card_rst, 1'b0);
        flt_pvc = 1'b0;
        tick(3 * DG);
        chk("R6 off after vpc<vcc", pwr_en, 1'b0);
        act_req_n = 1'b1;
        tick(2);

        // R2/R8: request with no card, then card inserted while request held.
        det_hi = 1'b0; det_lo_n = 1'b1;
        act_req_n = 1'b0;
        tick(3);
        chk("R2 no card no start", pwr_en, 1'b0);
        chk("R7 no card irq_n low", irq_n, 1'b0);
        det_lo_n = 1'b0;
        tick(3);
        chk("R8 inserted still locked", pwr_en, 1'b0);
        act_req_n = 1'b1;
        tick(1);
        act_req_n = 1'b0;
        tick(1);
        chk("R2 start via det_lo_n", pwr_en, 1'b1);

        // R5/R6: removal during power-up.
        tick(1);
        det_lo_n = 1'b1;
        tick(1);
        chk("R5 removal io_en off", io_en, 1'b0);
        tick(3 * DG - 1);
        chk("R6 pwr_en held", pwr_en, 1'b1);
        tick(1);
        chk("R6 pwr_en off after removal", pwr_en, 1'b0);
        act_req_n = 1'b1; #1;
        chk("R1 irq_n no card", irq_n, 1'b0);

        // R10: VDD fault while idle.
        det_hi = 1'b1; flt_vdd = 1'b1;
        tick(1);
        act_req_n = 1'b0;
        tick(3);
        chk("R10 held idle", pwr_en, 1'b0);
        chk("R10 irq_n low", irq_n, 1'b0);
        flt_vdd = 1'b0;
        tick(2);
        chk("R10 still idle", pwr_en, 1'b0);
        act_req_n = 1'b1;
        tick(1);
        chk("R10 irq_n released", irq_n, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule